// File: doc/BRIEF.md
# Prescaled Seconds Timer with Alarm

The block is a free-running elapsed-time counter that sits on a simple 32-bit register bus. A slow reference clock enters on a single pin. It passes through a synchroniser into the bus clock domain, where each rising edge becomes a one-cycle strobe. A programmable prescaler turns a fixed number of those strobes into one tick. Each tick advances the elapsed counter. When the slow clock runs at N Hz and the prescaler holds N, the counter counts seconds.

Software cannot load the counter. It can only ask for a restart, and the restart clears the prescaler and the counter together on the next slow edge. A full-width alarm comparator raises a sticky alarm flag on the tick where the counter reaches the alarm value. A second flag records every tick. Both flags clear when the status register is read. One interrupt line reports any flag whose enable bit is set. The enable bits sit exactly 16 places above the status bits they gate.

Top module: `secs_timer`

## Requirements
- R1: After reset, the mode register reads 0, the alarm register reads 0xFFFFFFFF, the count register reads 0, the status register reads 0 and `irq` is low. Offsets: mode 0x0, alarm 0x4, count 0x8, status 0xC. Any other offset reads 0.
- R2: The mode register bits 15:0 hold the divide value D. The count register advances by one on every D-th synchronised rising edge of `slow_clk`, counted from the last restart.
- R3: A divide value of 0 divides by 65536.
- R4: The count register is read-only. A bus write to offset 0x8 leaves the count unchanged.
- R5: Status bit 0 (alarm) sets on the tick where the count becomes equal to the alarm register. It stays set while the count moves past that value, until the status register is read.
- R6: Status bit 1 (increment) sets on every tick. Reading the status register returns both bits and clears them.
- R7: `irq` is high exactly when some status bit is set and its enable is set. Mode bit 16 enables the alarm flag and mode bit 17 enables the increment flag. A flag with its enable clear leaves `irq` low.
- R8: Writing 1 to mode bit 18 requests a restart. The bit reads 1 while the request waits. On the next synchronised slow edge the prescaler and the count go to 0, no tick occurs, and the bit reads 0 from then on.
- R9: A flag that sets in the same cycle as a status read survives the clear, and the next status read returns it.
- R10: The alarm register is read/write over its full 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Slow reference clock, asynchronous to `clk` |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_sel` is high |
| irq | output | 1 | Combined, enable-gated interrupt |

## Verification
A wrong prescaler phase or a lost tick shows up as a count that is off by one or more against the edge count divided by D. It is visible at the first count read after the next tick. A flag that clears too eagerly, or a broken enable alignment, appears on `irq` in the cycle after the status changes. The bench times one status read to coincide with a tick, which exposes a clear that overrides a new event. A stale restart request shows up as bit 18 reading 1, or as a count that is not 0, after the following slow edge.

// File: rtl/secs_timer_pkg.sv
package secs_timer_pkg;
   localparam int unsigned BUS_W       = 32;
   localparam int unsigned OFS_MODE    = 4'h0;
   localparam int unsigned OFS_ALARM   = 4'h4;
   localparam int unsigned OFS_COUNT   = 4'h8;
   localparam int unsigned OFS_STATUS  = 4'hC;
   localparam int unsigned FLAG_ALM    = 0;
   localparam int unsigned FLAG_INC    = 1;
   localparam int unsigned N_FLAGS     = 2;
   localparam int unsigned EN_SHIFT    = 16;
   localparam int unsigned RESTART_BIT = 18;

   typedef struct packed {
      logic alm;
      logic inc;
   } flag_evt_t;
endpackage

// File: rtl/secs_timer_sync.sv
module secs_timer_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("secs_timer_sync: STAGES must be at least 2");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/secs_timer_presc.sv
module secs_timer_presc #(
   parameter int unsigned PRESC_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               slow_edge,
   input  logic               restart,
   input  logic [PRESC_W-1:0] divide,
   output logic               tick_o
);
   localparam logic [PRESC_W-1:0] ALL_ONES = '1;

   logic [PRESC_W-1:0] phase_q;
   logic [PRESC_W-1:0] last_phase;

   // zero divide means the full 2**PRESC_W range
   assign last_phase = (divide == '0) ? ALL_ONES : divide - 1'b1;
   assign tick_o     = slow_edge & ~restart & (phase_q >= last_phase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (slow_edge) begin
         if (restart || tick_o) phase_q <= '0;
         else                   phase_q <= phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/secs_timer_count.sv
module secs_timer_count
   import secs_timer_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_edge,
   input  logic             restart,
   input  logic             tick,
   input  logic [CNT_W-1:0] alarm,
   output logic [CNT_W-1:0] count_o,
   output flag_evt_t        evt_o
);
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] count_nx;

   assign count_nx  = count_q + 1'b1;
   assign evt_o.inc = tick;
   assign evt_o.alm = tick & (count_nx == alarm);
   assign count_o   = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      count_q <= '0;
      else if (slow_edge && restart)   count_q <= '0;
      else if (tick)                   count_q <= count_nx;
   end
endmodule

// File: rtl/secs_timer_regs.sv
module secs_timer_regs
   import secs_timer_pkg::*;
#(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned PRESC_W = 16,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_write,
   input  logic [3:0]         bus_addr,
   input  logic [BUS_W-1:0]   bus_wdata,
   output logic [BUS_W-1:0]   bus_rdata,
   input  logic               slow_edge,
   input  flag_evt_t          evt,
   input  logic [CNT_W-1:0]   count,
   output logic [PRESC_W-1:0] divide_o,
   output logic [CNT_W-1:0]   alarm_o,
   output logic               restart_o,
   output logic               irq
);
   logic [PRESC_W-1:0] divide_q;
   logic [N_FLAGS-1:0] enable_q;
   logic               restart_q;
   logic [BUS_W-1:0]   alarm_q;
   logic [N_FLAGS-1:0] status_q;
   logic [N_FLAGS-1:0] status_set;
   logic               wr_mode, wr_alarm, rd_status;
   logic               irq_raw;

   assign wr_mode   = bus_sel &  bus_write & (bus_addr == 4'(OFS_MODE));
   assign wr_alarm  = bus_sel &  bus_write & (bus_addr == 4'(OFS_ALARM));
   assign rd_status = bus_sel & ~bus_write & (bus_addr == 4'(OFS_STATUS));

   always_comb begin
      status_set           = '0;
      status_set[FLAG_ALM] = evt.alm;
      status_set[FLAG_INC] = evt.inc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         divide_q <= '0;
         enable_q <= '0;
      end else if (wr_mode) begin
         divide_q <= bus_wdata[PRESC_W-1:0];
         enable_q <= bus_wdata[EN_SHIFT +: N_FLAGS];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         restart_q <= 1'b0;
      else if (wr_mode && bus_wdata[RESTART_BIT]) restart_q <= 1'b1;
      else if (slow_edge)                 restart_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        alarm_q <= '1;
      else if (wr_alarm) alarm_q <= bus_wdata;
   end

   // new events win over the clear of a concurrent read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         status_q <= '0;
      else if (rd_status) status_q <= status_set;
      else                status_q <= status_q | status_set;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_write) begin
         case (bus_addr)
            4'(OFS_MODE): begin
               bus_rdata[PRESC_W-1:0]            = divide_q;
               bus_rdata[EN_SHIFT +: N_FLAGS]    = enable_q;
               bus_rdata[RESTART_BIT]            = restart_q;
            end
            4'(OFS_ALARM):  bus_rdata = alarm_q;
            4'(OFS_COUNT):  bus_rdata[CNT_W-1:0] = count;
            4'(OFS_STATUS): bus_rdata[N_FLAGS-1:0] = status_q;
            default:        bus_rdata = '0;
         endcase
      end
   end

   assign irq_raw = |(status_q & enable_q);

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate

   assign divide_o  = divide_q;
   assign alarm_o   = alarm_q[CNT_W-1:0];
   assign restart_o = restart_q;
endmodule

// File: rtl/secs_timer.sv
module secs_timer
   import secs_timer_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned PRESC_W     = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IRQ_REG     = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        slow_clk,
   input  logic        bus_sel,
   input  logic        bus_write,
   input  logic [3:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq
);
   generate
      if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
         $error("secs_timer: CNT_W out of range");
      end
      if (PRESC_W < 1 || PRESC_W > EN_SHIFT) begin : g_bad_presc
         $error("secs_timer: PRESC_W must fit below the enable bits");
      end
   endgenerate

   logic               slow_edge;
   logic               tick;
   logic               restart;
   logic [PRESC_W-1:0] divide;
   logic [CNT_W-1:0]   alarm;
   logic [CNT_W-1:0]   count;
   flag_evt_t          evt;

   secs_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (slow_clk),
      .rise_o   (slow_edge)
   );

   secs_timer_presc #(.PRESC_W(PRESC_W)) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_edge (slow_edge),
      .restart   (restart),
      .divide    (divide),
      .tick_o    (tick)
   );

   secs_timer_count #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_edge (slow_edge),
      .restart   (restart),
      .tick      (tick),
      .alarm     (alarm),
      .count_o   (count),
      .evt_o     (evt)
   );

   secs_timer_regs #(
      .CNT_W   (CNT_W),
      .PRESC_W (PRESC_W),
      .IRQ_REG (IRQ_REG)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .slow_edge (slow_edge),
      .evt       (evt),
      .count     (count),
      .divide_o  (divide),
      .alarm_o   (alarm),
      .restart_o (restart),
      .irq       (irq)
   );
endmodule

// File: rtl/secs_timer_chk.sv
module secs_timer_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_write,
   input logic [3:0]       bus_addr,
   input logic             irq,
   input logic             slow_edge,
   input logic             tick,
   input logic             restart,
   input logic [CNT_W-1:0] count,
   input logic [1:0]       status_q,
   input logic [1:0]       enable_q
);
   logic rd_stat;
   assign rd_stat = bus_sel & ~bus_write & (bus_addr == 4'hC);

   // R2 R4: the count only moves by one on a tick, or to zero on restart
   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> ((count == $past(count) + 1'b1) && $past(tick))
                                  || (count == '0 && $past(restart) && $past(slow_edge)));

   // R8: a pending restart meeting a slow edge zeroes the count and retires
   p_restart_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && slow_edge) |=> (count == '0) && !restart);

   // R6: a status read with no new tick leaves both flags clear
   p_clear_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !tick) |=> (status_q == 2'b00));

   // R5: the alarm flag holds until a status read
   p_alarm_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[0] && !rd_stat) |=> status_q[0]);

   // R7: with no enable set the interrupt stays low
   p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_q == 2'b00) |-> !irq);
endmodule

bind secs_timer secs_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .irq       (irq),
   .slow_edge (slow_edge),
   .tick      (tick),
   .restart   (restart),
   .count     (count),
   .status_q  (u_regs.status_q),
   .enable_q  (u_regs.enable_q)
);

// File: tb/secs_timer_bench.sv
module secs_timer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_clk = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_write = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   secs_timer u_secs_timer (
      .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
      .bus_sel(bus_sel), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == WATCHDOG && !done) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); slow_clk = 1'b1;
         @(negedge clk); slow_clk = 1'b0;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic restart_with(input logic [31:0] mode);
      logic [31:0] d;
      wr(4'h0, mode | 32'h0004_0000);
      pulses(1);
      rd(4'hC, d);
   endtask

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(4'h0, d); check("R1 mode", d, 32'h0);
      rd(4'h4, d); check("R1 alarm", d, 32'hFFFF_FFFF);
      rd(4'h8, d); check("R1 count", d, 32'h0);
      rd(4'hC, d); check("R1 status", d, 32'h0);
      rd(4'h2, d); check("R1 unmapped", d, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);

      // R10: alarm read/write
      wr(4'h4, 32'hA5C3_0F96);
      rd(4'h4, d); check("R10 alarm rw", d, 32'hA5C3_0F96);
      wr(4'h4, 32'hFFFF_FFFF);

      // R2 R6: divide sweep, expected count = edges / D
      for (int dv = 1; dv <= 7; dv++) begin
         restart_with(dv);
         pulses(13);
         rd(4'h8, d); check("R2 count vs divide", d, 32'(13 / dv));
         rd(4'hC, d); check("R6 increment flag", d, (13 >= dv) ? 32'h2 : 32'h0);
         rd(4'hC, d); check("R6 cleared by read", d, 32'h0);
      end

      // R4: count is read-only
      wr(4'h8, 32'h0000_1234);
      rd(4'h8, d); check("R4 write ignored", d, 32'(13 / 7));

      // R8: restart request readback and effect
      wr(4'h0, 32'h0004_0003);
      rd(4'h0, d); check("R8 pending reads 1", d, 32'h0004_0003);
      pulses(1);
      rd(4'h0, d); check("R8 retired reads 0", d, 32'h0000_0003);
      rd(4'h8, d); check("R8 count zeroed", d, 32'h0);
      pulses(2);
      rd(4'h8, d); check("R8 prescaler zeroed", d, 32'h0);
      pulses(1);
      rd(4'h8, d); check("R8 first tick after 3", d, 32'h1);

      // R5 R7: alarm match, sticky, gating
      restart_with(32'h0000_0001);
      wr(4'h4, 32'd5);
      wr(4'h0, 32'h0001_0001);
      pulses(4);
      check("R7 inc flag not enabled", {31'b0, irq}, 32'h0);
      pulses(1);
      check("R7 alarm irq", {31'b0, irq}, 32'h1);
      pulses(2);
      check("R5 alarm sticky irq", {31'b0, irq}, 32'h1);
      rd(4'h8, d); check("R5 count past alarm", d, 32'd7);
      rd(4'hC, d); check("R5 flags", d, 32'h3);
      check("R7 irq after clear", {31'b0, irq}, 32'h0);
      wr(4'h0, 32'h0002_0001);
      pulses(1);
      check("R7 increment irq", {31'b0, irq}, 32'h1);
      rd(4'hC, d);
      wr(4'h4, 32'hFFFF_FFFF);

      // R9: tick coinciding with a status read survives
      wr(4'h0, 32'h0000_0001);
      rd(4'hC, d);
      @(negedge clk); slow_clk = 1'b1;
      @(negedge clk); slow_clk = 1'b0;
      @(negedge clk);
      bus_sel = 1'b1; bus_write = 1'b0; bus_addr = 4'hC;
      #1 d = bus_rdata;
      check("R9 old status", d, 32'h0);
      @(negedge clk); bus_sel = 1'b0;
      rd(4'hC, d); check("R9 flag survived", d, 32'h2);

      // R3: zero divide means 65536
      restart_with(32'h0000_0000);
      pulses(65535);
      rd(4'h8, d); check("R3 no tick before 65536", d, 32'h0);
      pulses(1);
      rd(4'h8, d); check("R3 tick at 65536", d, 32'h1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule